// File: doc/BRIEF.md
# Graphics DRAM Extended Mode Register Controller

This block is the device-side logic of a graphics DRAM that keeps the extended mode register and a second register that holds the low-power strobe termination bit. It captures either register when a mode-register-set strobe selects it. It loads safe termination defaults on its own once power and clock are stable. It also turns the stored fields into live controls for the on-die terminators, the preamble generator and the data bus inversion logic.

A small lock timer gates READ commands. After every DLL-enable event, a fixed number of cycles must pass before a READ is granted. A READ that arrives too early is refused and reported with a one-cycle violation pulse. A preamble field outside the legal range is clamped, and an error pulse reports it. Analog impedance calibration is not part of the block.

Top module: `emr_ctrl`

## Requirements
- R1: Termination code 00 (address bits 3:2 of an extended-register write) turns off data termination (`dq_term_en_o`=0), command/address termination (`ca_term_en_o`=0) and strobe-only termination.
- R2: Termination code 01 gives `dq_term_en_o`=0 and `ca_term_en_o`=1.
- R3: Termination codes 10 and 11 give `dq_term_en_o`=1 and `ca_term_en_o`=1, with `term_half_o`=0 (quarter of ZQ, dual load) for 10 and `term_half_o`=1 (half of ZQ, single load) for 11.
- R4: `strobe_term_o` equals bit 5 of the last write to the second register (select `SEL_EXT3`) when the termination code is 10 or 11, and is 0 for codes 00 and 01.
- R5: `preamble_o` equals address bits 6:4 of the last extended-register write when that value is 1 to 5. It is 1 for 0 and 5 for 6 or 7. For an illegal value, `pre_err_o` is high in the cycle after the write and low in the cycle after that.
- R6: `rd_dbi_o`, `wr_dbi_o` and `dbi_mode_o` equal address bits 8, 9 and 10 of the last extended-register write.
- R7: After reset, all terminations are off, `init_busy_o`=0, `rd_ok_o`=0 and `preamble_o`=`DEF_PRE` (1). Register writes are ignored until `pwr_stable_i` has been seen high.
- R8: In the first cycle in which `pwr_stable_i` is seen high, the termination code takes `DEF_TERM` (01) and the low-power bit takes 0. `init_busy_o` is then high for exactly `INIT_CYC` cycles.
- R9: A write inside the initialization window takes effect in the next cycle, and the default does not overwrite it afterwards.
- R10: `rd_ok_o` goes low in the cycle after a `dll_en_i` event and goes high `TDL` cycles after that event. A new event restarts the wait.
- R11: `rd_grant_o` is `rd_req_i` AND `rd_ok_o` in the same cycle. A request seen while `rd_ok_o`=0 makes `rd_viol_o` high for the next cycle only.
- R12: A write whose select matches neither `SEL_EXT` (1) nor `SEL_EXT3` (3) changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_stable_i | input | 1 | Power and clock are stable |
| mrs_i | input | 1 | Mode-register-set strobe |
| mrs_sel_i | input | SELW | Register select for the write |
| mrs_addr_i | input | AW | Address bus carrying the register image |
| dll_en_i | input | 1 | DLL-enable event |
| rd_req_i | input | 1 | READ request |
| dq_term_en_o | output | 1 | Data, data-mask and write-strobe termination on |
| ca_term_en_o | output | 1 | Command/address termination on |
| term_half_o | output | 1 | 1: half ZQ, 0: quarter ZQ |
| strobe_term_o | output | 1 | Low-power strobe-only termination active |
| preamble_o | output | 3 | Preamble length in clock cycles (1 to 5) |
| rd_dbi_o | output | 1 | Read data bus inversion on |
| wr_dbi_o | output | 1 | Write data bus inversion on |
| dbi_mode_o | output | 1 | Data bus inversion mode select |
| pre_err_o | output | 1 | One-cycle pulse: illegal preamble was written |
| init_busy_o | output | 1 | Initialization window active |
| rd_ok_o | output | 1 | DLL lock delay has elapsed |
| rd_grant_o | output | 1 | READ accepted this cycle |
| rd_viol_o | output | 1 | One-cycle pulse: READ was refused |

## Verification
The checker holds these properties on every cycle: data termination never appears without command/address termination, strobe-only termination never appears without data termination, and the preamble stays in its legal range. It also checks that error pulses have a cause, that grants need the lock flag, that refused requests pulse, and that the window opens with command/address termination on. Other behaviour needs the bench's scenarios. These are the exact code-to-output tables, the clamp values, the length of the window and of the lock delay, that a write beats the default inside the window, and that writes before power-stable or to foreign selects leave the outputs unchanged.

// File: rtl/emr_pkg.sv
package emr_pkg;

  localparam int TERM_LSB = 2;
  localparam int PRE_LSB  = 4;
  localparam int RDBI_BIT = 8;
  localparam int WDBI_BIT = 9;
  localparam int MODE_BIT = 10;
  localparam int LP_BIT   = 5;
  localparam int MIN_AW   = 11;

  localparam logic [2:0] PRE_MIN = 3'd1;
  localparam logic [2:0] PRE_MAX = 3'd5;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_WIN  = 2'd1,
    ST_RUN  = 2'd2
  } init_st_e;

  typedef struct packed {
    logic [1:0] term;
    logic [2:0] pre;
    logic       rd_dbi;
    logic       wr_dbi;
    logic       dbi_mode;
  } ext_t;

  function automatic logic pre_legal(input logic [2:0] p);
    return (p >= PRE_MIN) && (p <= PRE_MAX);
  endfunction

  function automatic logic [2:0] pre_clamp(input logic [2:0] p);
    if (p < PRE_MIN) return PRE_MIN;
    if (p > PRE_MAX) return PRE_MAX;
    return p;
  endfunction

  function automatic logic term_dq(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic term_ca(input logic [1:0] code);
    return code != 2'b00;
  endfunction

  function automatic logic term_half(input logic [1:0] code);
    return code == 2'b11;
  endfunction

endpackage

// File: rtl/emr_regs.sv
module emr_regs
  import emr_pkg::*;
#(
  parameter int         AW       = 11,
  parameter int         SELW     = 2,
  parameter int         SEL_EXT  = 1,
  parameter int         SEL_EXT3 = 3,
  parameter logic [1:0] DEF_TERM = 2'b01,
  parameter int         DEF_PRE  = 1,
  parameter int         INIT_CYC = 10000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_stable_i,
  input  logic            mrs_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [AW-1:0]   addr_i,
  output ext_t            ext_o,
  output logic            lp_o,
  output logic            init_busy_o,
  output logic            pre_err_o,
  output logic            load_def_o,
  output logic            wr_ext_o,
  output logic            wr_ext3_o
);

  localparam int         WCW       = $clog2(INIT_CYC + 1);
  localparam logic [1:0] SAFE_TERM = (DEF_TERM == 2'b00) ? 2'b01 : DEF_TERM;
  localparam logic [2:0] RST_PRE   = 3'(DEF_PRE);

  init_st_e       st_q;
  logic [WCW-1:0] wcnt_q;
  ext_t           ext_q;
  logic           lp_q;
  logic           perr_q;
  logic           accept;
  logic [2:0]     pre_field;

  assign accept     = mrs_i && (st_q != ST_WAIT);
  assign wr_ext_o   = accept && (sel_i == SELW'(SEL_EXT));
  assign wr_ext3_o  = accept && (sel_i == SELW'(SEL_EXT3));
  assign load_def_o = (st_q == ST_WAIT) && pwr_stable_i;
  assign pre_field  = addr_i[PRE_LSB +: 3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      wcnt_q <= '0;
      ext_q  <= '{term: 2'b00, pre: RST_PRE, rd_dbi: 1'b0, wr_dbi: 1'b0, dbi_mode: 1'b0};
      lp_q   <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      perr_q <= wr_ext_o && !pre_legal(pre_field);
      case (st_q)
        ST_WAIT: begin
          if (pwr_stable_i) begin
            st_q       <= ST_WIN;
            wcnt_q     <= WCW'(INIT_CYC - 1);
            ext_q.term <= SAFE_TERM;
            lp_q       <= 1'b0;
          end
        end
        ST_WIN: begin
          if (wcnt_q == '0) st_q <= ST_RUN;
          else              wcnt_q <= wcnt_q - 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
      if (wr_ext_o) begin
        ext_q.term     <= addr_i[TERM_LSB +: 2];
        ext_q.pre      <= pre_field;
        ext_q.rd_dbi   <= addr_i[RDBI_BIT];
        ext_q.wr_dbi   <= addr_i[WDBI_BIT];
        ext_q.dbi_mode <= addr_i[MODE_BIT];
      end
      if (wr_ext3_o) lp_q <= addr_i[LP_BIT];
    end
  end

  assign ext_o       = ext_q;
  assign lp_o        = lp_q;
  assign init_busy_o = (st_q == ST_WIN);
  assign pre_err_o   = perr_q;

endmodule

// File: rtl/emr_decode.sv
module emr_decode
  import emr_pkg::*;
(
  input  ext_t       ext_i,
  input  logic       lp_i,
  output logic       dq_term_en_o,
  output logic       ca_term_en_o,
  output logic       term_half_o,
  output logic       strobe_term_o,
  output logic [2:0] preamble_o,
  output logic       rd_dbi_o,
  output logic       wr_dbi_o,
  output logic       dbi_mode_o
);

  logic dq_on;

  always_comb begin
    dq_on         = term_dq(ext_i.term);
    dq_term_en_o  = dq_on;
    ca_term_en_o  = term_ca(ext_i.term);
    term_half_o   = dq_on && term_half(ext_i.term);
    strobe_term_o = dq_on && lp_i;
    preamble_o    = pre_clamp(ext_i.pre);
    rd_dbi_o      = ext_i.rd_dbi;
    wr_dbi_o      = ext_i.wr_dbi;
    dbi_mode_o    = ext_i.dbi_mode;
  end

endmodule

// File: rtl/emr_dll_gate.sv
module emr_dll_gate #(
  parameter int TDL = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dll_en_i,
  input  logic rd_req_i,
  output logic rd_ok_o,
  output logic rd_grant_o,
  output logic rd_viol_o
);

  localparam int CW = $clog2(TDL + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          viol_q;
  logic          ok;

  assign ok = armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= rd_req_i && !ok;
      if (dll_en_i) begin
        cnt_q   <= CW'(TDL);
        armed_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign rd_ok_o    = ok;
  assign rd_grant_o = rd_req_i && ok;
  assign rd_viol_o  = viol_q;

endmodule

// File: rtl/emr_ctrl.sv
module emr_ctrl
  import emr_pkg::*;
#(
  parameter int         AW       = 11,
  parameter int         SELW     = 2,
  parameter int         SEL_EXT  = 1,
  parameter int         SEL_EXT3 = 3,
  parameter logic [1:0] DEF_TERM = 2'b01,
  parameter int         DEF_PRE  = 1,
  parameter int         INIT_CYC = 10000,
  parameter int         TDL      = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_stable_i,
  input  logic            mrs_i,
  input  logic [SELW-1:0] mrs_sel_i,
  input  logic [AW-1:0]   mrs_addr_i,
  input  logic            dll_en_i,
  input  logic            rd_req_i,
  output logic            dq_term_en_o,
  output logic            ca_term_en_o,
  output logic            term_half_o,
  output logic            strobe_term_o,
  output logic [2:0]      preamble_o,
  output logic            rd_dbi_o,
  output logic            wr_dbi_o,
  output logic            dbi_mode_o,
  output logic            pre_err_o,
  output logic            init_busy_o,
  output logic            rd_ok_o,
  output logic            rd_grant_o,
  output logic            rd_viol_o
);

  ext_t ext_w;
  logic lp_w;
  logic load_def_w;
  logic wr_ext_w;
  logic wr_ext3_w;

  emr_regs #(
    .AW(AW), .SELW(SELW), .SEL_EXT(SEL_EXT), .SEL_EXT3(SEL_EXT3),
    .DEF_TERM(DEF_TERM), .DEF_PRE(DEF_PRE), .INIT_CYC(INIT_CYC)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_stable_i (pwr_stable_i),
    .mrs_i        (mrs_i),
    .sel_i        (mrs_sel_i),
    .addr_i       (mrs_addr_i),
    .ext_o        (ext_w),
    .lp_o         (lp_w),
    .init_busy_o  (init_busy_o),
    .pre_err_o    (pre_err_o),
    .load_def_o   (load_def_w),
    .wr_ext_o     (wr_ext_w),
    .wr_ext3_o    (wr_ext3_w)
  );

  emr_decode u_dec (
    .ext_i         (ext_w),
    .lp_i          (lp_w),
    .dq_term_en_o  (dq_term_en_o),
    .ca_term_en_o  (ca_term_en_o),
    .term_half_o   (term_half_o),
    .strobe_term_o (strobe_term_o),
    .preamble_o    (preamble_o),
    .rd_dbi_o      (rd_dbi_o),
    .wr_dbi_o      (wr_dbi_o),
    .dbi_mode_o    (dbi_mode_o)
  );

  emr_dll_gate #(.TDL(TDL)) u_dll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dll_en_i   (dll_en_i),
    .rd_req_i   (rd_req_i),
    .rd_ok_o    (rd_ok_o),
    .rd_grant_o (rd_grant_o),
    .rd_viol_o  (rd_viol_o)
  );

endmodule

// File: rtl/emr_ctrl_chk.sv
module emr_ctrl_chk #(
  parameter int SELW    = 2,
  parameter int SEL_EXT = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mrs_i,
  input logic [SELW-1:0] mrs_sel_i,
  input logic            dll_en_i,
  input logic            rd_req_i,
  input logic            dq_term_en_o,
  input logic            ca_term_en_o,
  input logic            strobe_term_o,
  input logic [2:0]      preamble_o,
  input logic            pre_err_o,
  input logic            init_busy_o,
  input logic            rd_ok_o,
  input logic            rd_grant_o,
  input logic            rd_viol_o,
  input logic            wr_ext_w
);

  AST_DQ_NEEDS_CA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_term_en_o |-> ca_term_en_o); // R1
  AST_STROBE_NEEDS_DQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_term_o |-> dq_term_en_o); // R4
  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preamble_o >= 3'd1) && (preamble_o <= 3'd5)); // R5
  AST_PRE_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_err_o |-> ($past(mrs_i) && $past(mrs_sel_i) == SELW'(SEL_EXT))); // R5
  AST_PRE_ERR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_err_o |-> $past(wr_ext_w)); // R5
  AST_WINDOW_CA_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_busy_o) |-> (ca_term_en_o && !strobe_term_o)); // R8
  AST_LOCK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_en_i |=> !rd_ok_o); // R10
  AST_GRANT_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_grant_o |-> rd_ok_o); // R11
  AST_REFUSE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_ok_o) |=> rd_viol_o); // R11
  AST_VIOL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_viol_o |-> $past(rd_req_i && !rd_ok_o)); // R11

endmodule

bind emr_ctrl emr_ctrl_chk #(.SELW(SELW), .SEL_EXT(SEL_EXT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mrs_i         (mrs_i),
  .mrs_sel_i     (mrs_sel_i),
  .dll_en_i      (dll_en_i),
  .rd_req_i      (rd_req_i),
  .dq_term_en_o  (dq_term_en_o),
  .ca_term_en_o  (ca_term_en_o),
  .strobe_term_o (strobe_term_o),
  .preamble_o    (preamble_o),
  .pre_err_o     (pre_err_o),
  .init_busy_o   (init_busy_o),
  .rd_ok_o       (rd_ok_o),
  .rd_grant_o    (rd_grant_o),
  .rd_viol_o     (rd_viol_o),
  .wr_ext_w      (wr_ext_w)
);

// File: tb/tb_emr_ctrl.sv
module tb_emr_ctrl;

  localparam int AW = 11;
  localparam int SELW = 2;
  localparam int INIT_CYC = 8;
  localparam int TDL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0;
  logic mrs = 1'b0;
  logic [SELW-1:0] sel = '0;
  logic [AW-1:0] addr = '0;
  logic dll_en = 1'b0;
  logic rd_req = 1'b0;
  logic dq, ca, half, strb, rdbi, wdbi, dmode, perr, busy, rok, grant, viol;
  logic [2:0] pre;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  emr_ctrl #(.AW(AW), .SELW(SELW), .SEL_EXT(1), .SEL_EXT3(3), .DEF_TERM(2'b01),
             .DEF_PRE(1), .INIT_CYC(INIT_CYC), .TDL(TDL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_stable_i(pwr), .mrs_i(mrs), .mrs_sel_i(sel),
    .mrs_addr_i(addr), .dll_en_i(dll_en), .rd_req_i(rd_req),
    .dq_term_en_o(dq), .ca_term_en_o(ca), .term_half_o(half), .strobe_term_o(strb),
    .preamble_o(pre), .rd_dbi_o(rdbi), .wr_dbi_o(wdbi), .dbi_mode_o(dmode),
    .pre_err_o(perr), .init_busy_o(busy), .rd_ok_o(rok), .rd_grant_o(grant),
    .rd_viol_o(viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input int s, input int a);
    @(negedge clk);
    mrs = 1'b1; sel = SELW'(s); addr = AW'(a);
    @(negedge clk);
    mrs = 1'b0; sel = '0; addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pwr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic power_up();
    @(negedge clk);
    pwr = 1'b1;
    @(negedge clk);
  endtask

  task automatic dll_pulse();
    @(negedge clk);
    dll_en = 1'b1;
    @(negedge clk);
    dll_en = 1'b0;
  endtask

  task automatic check_term(input string req, input int c, input int lp);
    chk({req, " dq"}, int'(dq), (c >> 1) & 1);
    chk({req, " ca"}, int'(ca), (c != 0) ? 1 : 0);
    chk({req, " half"}, int'(half), (c == 3) ? 1 : 0);
    chk({req, " strobe"}, int'(strb), ((c >> 1) & 1) & lp);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check_term("R7 reset", 0, 0);
    chk("R7 busy", int'(busy), 0);
    chk("R7 rd_ok", int'(rok), 0);
    chk("R7 preamble", int'(pre), 1);
    // R7 write before power stable is ignored
    write(1, (3 << 2) | (4 << 4) | (7 << 8));
    check_term("R7 early write", 0, 0);
    chk("R7 early pre", int'(pre), 1);
    chk("R7 early dbi", int'(rdbi), 0);

    // R8 defaults and window length
    power_up();
    check_term("R8 default", 1, 0);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R8 window cycles", cnt, INIT_CYC);
    check_term("R8 after window", 1, 0);

    // R9 write inside window
    do_reset();
    power_up();
    chk("R9 busy", int'(busy), 1);
    write(1, (3 << 2) | (1 << 4));
    chk("R9 busy still", int'(busy), 1);
    check_term("R9 next cycle", 3, 0);
    while (busy) @(negedge clk);
    check_term("R9 after window", 3, 0);

    // R1 R2 R3 R4 termination sweep
    for (int c = 0; c < 4; c++) begin
      for (int lp = 0; lp < 2; lp++) begin
        write(3, lp << 5);
        write(1, (c << 2) | (1 << 4));
        check_term("R1-4 sweep", c, lp);
        if (c == 0) check_term("R1", c, lp);
        else if (c == 1) check_term("R2", c, lp);
        else check_term("R3", c, lp);
        chk("R4 strobe", int'(strb), (c >= 2) ? lp : 0);
      end
    end

    // R5 preamble sweep
    for (int p = 0; p < 8; p++) begin
      write(1, (3 << 2) | (p << 4));
      chk("R5 preamble", int'(pre), (p == 0) ? 1 : (p > 5) ? 5 : p);
      chk("R5 err", int'(perr), (p == 0 || p > 5) ? 1 : 0);
      @(negedge clk);
      chk("R5 err drop", int'(perr), 0);
    end

    // R6 DBI sweep
    for (int d = 0; d < 8; d++) begin
      write(1, (2 << 2) | (3 << 4) | (d << 8));
      chk("R6 rd dbi", int'(rdbi), d & 1);
      chk("R6 wr dbi", int'(wdbi), (d >> 1) & 1);
      chk("R6 mode", int'(dmode), (d >> 2) & 1);
    end

    // R12 foreign selects ignored
    write(3, 1 << 5);
    write(1, (3 << 2) | (2 << 4) | (5 << 8));
    write(0, '1);
    write(2, 0);
    check_term("R12 foreign", 3, 1);
    chk("R12 pre", int'(pre), 2);
    chk("R12 rd dbi", int'(rdbi), 1);
    chk("R12 wr dbi", int'(wdbi), 0);
    chk("R12 mode", int'(dmode), 1);

    // R11 refusal before lock
    @(negedge clk);
    rd_req = 1'b1;
    #1;
    chk("R11 grant early", int'(grant), 0);
    @(negedge clk);
    rd_req = 1'b0;
    chk("R11 viol", int'(viol), 1);
    @(negedge clk);
    chk("R11 viol drop", int'(viol), 0);

    // R10 lock delay
    dll_pulse();
    chk("R10 ok low", int'(rok), 0);
    repeat (2) @(negedge clk);
    dll_pulse();
    repeat (TDL - 1) @(negedge clk);
    chk("R10 restart not yet", int'(rok), 0);
    @(negedge clk);
    chk("R10 restart ok", int'(rok), 1);
    rd_req = 1'b1;
    #1;
    chk("R11 grant", int'(grant), 1);
    @(negedge clk);
    rd_req = 1'b0;
    chk("R11 no viol", int'(viol), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule